// File: doc/BRIEF.md
# Table-Driven Interrupt Vector Resolver

This block turns an accepted vectored interrupt into the 16-bit start address of its service routine, as a processor does in its table-based interrupt mode. When a request is pending and the unit is idle, it runs a one-cycle acknowledge, during which the interrupting device places an 8-bit vector on the bus. The unit joins that vector, as the low byte, with a page byte held in a software-loaded register to form a table pointer.

It then reads two bytes through a request/ready read port, one at the pointer and one at the next address, and combines them into the routine address. It presents that address with a one-cycle done pulse. The vector is used exactly as supplied, so odd vectors and tables at unaligned bases are legal. The second address is a full 16-bit increment, so an entry that begins at the last byte of a page takes its high byte from the first byte of the next page.

Top module: `irq_vector_resolver`

## Requirements
- R1: A synchronous active-low reset puts the unit in idle, with `ack`, `rd_req` and `done` low, `target` at 0x0000 and the page register at 0x00. A reset in the middle of a sequence abandons it.
- R2: A pending interrupt seen while idle raises `ack` in the next cycle, for exactly one cycle per sequence. `ack_vec` is sampled in that cycle.
- R3: The first read address has the page register as its upper byte and the sampled vector as its lower byte, with bit 0 kept as supplied, odd values included.
- R4: The second read address is the first plus one as a 16-bit sum, carrying into the upper byte. 0x20FF is followed by 0x2100, and 0xFFFF is followed by 0x0000.
- R5: During each read, `rd_req` stays high with `rd_addr` unchanged until `rd_ready` is high. `rd_data` is taken only in a cycle where `rd_ready` is high.
- R6: The byte from the first read becomes `target[7:0]` and the byte from the second read becomes `target[15:8]`.
- R7: After the second read is accepted, `done` is high for exactly one cycle with `target` valid. The unit then returns to idle, and `target` keeps its value until the next sequence.
- R8: While a sequence is in progress, `irq_pend` is ignored. A request that is held high throughout produces only one acknowledge before the unit is idle again.
- R9: `page_we` high loads `page_wdata` into the page register. The value is kept across any number of interrupts.
- R10: A page load during a sequence does not change the addresses of that sequence. The pointer is fixed when the vector is sampled, and the new page applies from the next sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| page_we | input | 1 | Load strobe for the page register |
| page_wdata | input | 8 | Page byte to load |
| irq_pend | input | 1 | Interrupt pending |
| ack | output | 1 | Acknowledge cycle; the device drives its vector |
| ack_vec | input | 8 | Vector from the device, sampled while `ack` is high |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_ready | input | 1 | Read data valid; completes the read |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle pulse: `target` is valid |
| target | output | 16 | Resolved service routine address |

## Verification
The hardest states to reach from the ports are a table entry that crosses a page boundary and a page load that arrives while a sequence is already reading. The bench places known bytes at 0x20FF/0x2100 and at 0xFFFF/0x0000 and triggers vectors 0xFF there, so that only a carrying increment gives the expected target. It also pulses the page load while the read port is held waiting, then checks that the current sequence keeps the old page and the next one uses the new page. A reset asserted during a long read wait covers abandoning a sequence part-way.

// File: rtl/irqvr_pkg.sv
// Package: shared types for the interrupt vector resolver.
// Assumes: nothing beyond the enum encoding being private to the block.
package irqvr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACK   = 3'd1,
        ST_RD_LO = 3'd2,
        ST_RD_HI = 3'd3,
        ST_DONE  = 3'd4
    } irqvr_state_e;

endpackage

// File: rtl/irqvr_page_reg.sv
// Module: irqvr_page_reg
// Holds the table page byte, loaded through a write strobe.
// Assumes: synchronous active-low reset clears the page to zero.
module irqvr_page_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] page
);

    // Page storage: cleared by reset, replaced on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (we) begin
            page <= wdata;
        end
    end

endmodule

// File: rtl/irqvr_ptr_gen.sv
// Module: irqvr_ptr_gen
// Freezes the table pointer {page, vector} when the vector is sampled, and
// produces the read address: the pointer, or the pointer plus one with a
// full carry into the page byte.
// Assumes: latch is high in exactly the acknowledge cycle.
module irqvr_ptr_gen #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch,
    input  logic [BYTE_W-1:0]   page,
    input  logic [BYTE_W-1:0]   vec,
    input  logic                sel_hi,
    output logic [2*BYTE_W-1:0] addr
);

    localparam int ADDR_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] ptr_q;

    // Pointer register: captured once per sequence, with vector bit 0 untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (latch) begin
            ptr_q <= {page, vec};
        end
    end

    // Address select: the second byte uses a full-width increment that wraps.
    always_comb begin
        addr = sel_hi ? (ptr_q + ADDR_W'(1)) : ptr_q;
    end

endmodule

// File: rtl/irqvr_seq.sv
// Module: irqvr_seq
// Sequencer: idle -> acknowledge -> read low byte -> read high byte -> done.
// Captures the low byte, then assembles the little-endian target.
// Assumes: rd_ready is only meaningful while rd_req is high.
module irqvr_seq
    import irqvr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pend,
    input  logic                rd_ready,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                ack,
    output logic                latch,
    output logic                rd_req,
    output logic                sel_hi,
    output logic                done,
    output logic [2*BYTE_W-1:0] target
);

    irqvr_state_e      state_q, state_d;
    logic [BYTE_W-1:0] lo_q;

    // Next-state logic: a request is considered only in idle, and reads wait for ready.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (irq_pend) state_d = ST_ACK;
            ST_ACK:   state_d = ST_RD_LO;
            ST_RD_LO: if (rd_ready) state_d = ST_RD_HI;
            ST_RD_HI: if (rd_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data capture: low byte on the first accepted read, full target on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            target <= '0;
        end else if (rd_ready && state_q == ST_RD_LO) begin
            lo_q <= rd_data;
        end else if (rd_ready && state_q == ST_RD_HI) begin
            target <= {rd_data, lo_q};
        end
    end

    // Output decode from the current state.
    always_comb begin
        ack    = (state_q == ST_ACK);
        latch  = (state_q == ST_ACK);
        rd_req = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        sel_hi = (state_q == ST_RD_HI);
        done   = (state_q == ST_DONE);
    end

endmodule

// File: rtl/irq_vector_resolver.sv
// Module: irq_vector_resolver (top)
// Resolves a vectored interrupt into a 16-bit service routine address by
// reading a two-byte entry from a table addressed by {page, vector}.
// Assumes: the device holds ack_vec valid while ack is high; the memory
// behind the read port answers each request with rd_ready eventually.
module irq_vector_resolver #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_we,
    input  logic [BYTE_W-1:0]   page_wdata,
    input  logic                irq_pend,
    output logic                ack,
    input  logic [BYTE_W-1:0]   ack_vec,
    output logic                rd_req,
    output logic [2*BYTE_W-1:0] rd_addr,
    input  logic                rd_ready,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                done,
    output logic [2*BYTE_W-1:0] target
);

    logic [BYTE_W-1:0] page_q;
    logic              latch;
    logic              sel_hi;

    irqvr_page_reg #(.BYTE_W(BYTE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page_q)
    );

    irqvr_ptr_gen #(.BYTE_W(BYTE_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .latch  (latch),
        .page   (page_q),
        .vec    (ack_vec),
        .sel_hi (sel_hi),
        .addr   (rd_addr)
    );

    irqvr_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_pend (irq_pend),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .ack      (ack),
        .latch    (latch),
        .rd_req   (rd_req),
        .sel_hi   (sel_hi),
        .done     (done),
        .target   (target)
    );

endmodule

// File: rtl/irq_vector_resolver_chk.sv
// Module: irq_vector_resolver_chk
// Protocol and address checks for the resolver, attached by bind.
// Assumes: page is the resolver's internal page register output.
module irq_vector_resolver_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ack,
    input logic [BYTE_W-1:0]   ack_vec,
    input logic [BYTE_W-1:0]   page,
    input logic                rd_req,
    input logic [2*BYTE_W-1:0] rd_addr,
    input logic                rd_ready,
    input logic                done
);

    localparam int ADDR_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] exp_ptr;
    logic              hi_ph;

    // Reference pointer, taken independently from page and vector at acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_ptr <= '0;
        end else if (ack) begin
            exp_ptr <= {page, ack_vec};
        end
    end

    // Read phase tracker: flips on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ph <= 1'b0;
        end else if (rd_req && rd_ready) begin
            hi_ph <= !hi_ph;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!ack && !rd_req && !done));

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !hi_ph) |-> (rd_addr == exp_ptr));

    p_second_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hi_ph) |-> (rd_addr == exp_ptr + ADDR_W'(1)));

    p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_req && rd_ready));

    p_busy_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || done) |-> !ack);

endmodule

bind irq_vector_resolver irq_vector_resolver_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .ack_vec  (ack_vec),
    .page     (page_q),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .done     (done)
);

// File: tb/irq_vector_resolver_tb.sv
module irq_vector_resolver_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        irq_pend = 1'b0;
    logic        ack;
    logic [7:0]  ack_vec = '0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data = 8'hEE;
    logic        done;
    logic [15:0] target;

    always #2 clk = ~clk;   // 250 MHz

    irq_vector_resolver #(.BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .irq_pend(irq_pend), .ack(ack), .ack_vec(ack_vec), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .target(target)
    );

    typedef struct {
        logic [15:0] a0;
        logic [15:0] a1;
        logic [15:0] tgt;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] got[$];
    logic [7:0]  ovr [logic [15:0]];
    int n_tests = 0, n_fail = 0;
    int n_done = 0, ack_total = 0, n_seq = 0, ack_in_seq = 0;
    int lat = 0, waitc = 0;
    bit done_prev = 0;

    function automatic logic [7:0] mem_rd(logic [15:0] a);
        if (ovr.exists(a)) return ovr[a];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic void check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endfunction

    // Memory responder: answers after lat waiting cycles, garbage data otherwise.
    initial forever begin
        @(posedge clk); #1;
        if (rd_req && rst_n) begin
            if (waitc >= lat) begin
                rd_ready = 1'b1; rd_data = mem_rd(rd_addr); waitc = 0;
            end else begin
                rd_ready = 1'b0; rd_data = 8'hEE; waitc++;
            end
        end else begin
            rd_ready = 1'b0; rd_data = 8'hEE; waitc = 0;
        end
    end

    // Monitor: collects accepted read addresses and scores each done pulse.
    initial forever begin
        @(negedge clk);
        if (!rst_n) begin
            got.delete(); ack_in_seq = 0; done_prev = 0;
        end else begin
            if (ack) begin ack_in_seq++; ack_total++; end
            if (rd_req && rd_ready) got.push_back(rd_addr);
            if (done) begin
                check("R7", "done wider than one cycle", 32'(done_prev), 32'd0);
                n_done++;
                if (sb.size() == 0) begin
                    check("R8", "done with nothing expected", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R5", {e.tag, " read count"}, 32'(got.size()), 32'd2);
                    if (got.size() == 2) begin
                        check("R3", {e.tag, " first address"}, 32'(got[0]), 32'(e.a0));
                        check("R4", {e.tag, " second address"}, 32'(got[1]), 32'(e.a1));
                    end
                    check("R6", {e.tag, " target"}, 32'(target), 32'(e.tgt));
                    check("R2", {e.tag, " acks in sequence"}, 32'(ack_in_seq), 32'd1);
                end
                got.delete(); ack_in_seq = 0;
            end
            done_prev = done;
        end
    end

    task automatic set_page(input logic [7:0] p);
        @(negedge clk); page_we = 1'b1; page_wdata = p;
        @(negedge clk); page_we = 1'b0;
    endtask

    // Driver: pushes the expected item, raises the request and holds it to done.
    task automatic fire(input logic [7:0] vec, input logic [7:0] pg, input int l,
                        input string tag, input bit pgw, input logic [7:0] newpg);
        logic [15:0] p;
        int start;
        bit wrote;
        wrote = 0;
        @(negedge clk);
        lat = l;
        p = {pg, vec};
        sb.push_back('{p, p + 16'd1, {mem_rd(p + 16'd1), mem_rd(p)}, tag});
        ack_vec = vec; irq_pend = 1'b1; start = n_done; n_seq++;
        while (n_done == start) begin
            @(negedge clk);
            if (pgw && rd_req && !wrote) begin
                page_we = 1'b1; page_wdata = newpg; wrote = 1;
            end else begin
                page_we = 1'b0;
            end
        end
        page_we = 1'b0; irq_pend = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R8", {tag, " no extra acknowledge"}, 32'(ack_total), 32'(n_seq));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ovr[16'h20E1] = 8'hCD; ovr[16'h20E2] = 8'hAB;
        ovr[16'h20FF] = 8'h34; ovr[16'h2100] = 8'h12;
        ovr[16'hFFFF] = 8'h78; ovr[16'h0000] = 8'h56;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ack after reset", 32'(ack), 0);
        check("R1", "rd_req after reset", 32'(rd_req), 0);
        check("R1", "done after reset", 32'(done), 0);
        check("R1", "target after reset", 32'(target), 0);

        fire(8'h40, 8'h00, 0, "R1 cleared page", 0, 8'h00);
        set_page(8'h20);
        fire(8'hE1, 8'h20, 0, "R3 odd vector unaligned table", 0, 8'h00);
        fire(8'hFF, 8'h20, 2, "R4 page carry", 0, 8'h00);
        check("R4", "carry entry target", 32'(target), 32'h1234);
        fire(8'h80, 8'h20, 3, "R5 slow memory", 0, 8'h00);
        set_page(8'hFF);
        fire(8'hFF, 8'hFF, 1, "R4 wrap to zero", 0, 8'h00);
        check("R6", "wrap entry target", 32'(target), 32'h5678);
        set_page(8'h31);
        fire(8'h10, 8'h31, 4, "R10 page load mid-sequence", 1, 8'h7C);
        fire(8'h22, 8'h7C, 0, "R9 new page applies", 0, 8'h00);
        repeat (6) @(negedge clk);
        check("R7", "target held while idle", 32'(target), 32'({mem_rd(16'h7C23), mem_rd(16'h7C22)}));
        fire(8'h23, 8'h7C, 1, "R9 page held", 0, 8'h00);

        // Reset in the middle of a long read wait.
        @(negedge clk);
        lat = 50; ack_vec = 8'h11; irq_pend = 1'b1;
        while (!rd_req) @(negedge clk);
        rst_n = 1'b0; irq_pend = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_req after mid-sequence reset", 32'(rd_req), 0);
        check("R1", "target after mid-sequence reset", 32'(target), 0);
        ack_total = 0; n_seq = 0;
        fire(8'h55, 8'h00, 0, "R1 page cleared again", 0, 8'h00);

        check("R7", "scoreboard drained", 32'(sb.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule